// File: doc/BRIEF.md
# Serial Peripheral Master with Programmable Idle Data Level

This block is a single-unit serial peripheral master. A one-cycle start strobe loads a data word and latches the clock polarity and phase. The block then lowers the active-low select line and shifts the word out, most significant bit first, on a serial clock derived from the system clock by a fixed even divisor. At the same time it collects the input line into a receive register. When the unit is complete the select line returns high, a one-cycle done pulse marks the received word as valid, and a minimum gap is enforced before the next access can begin.

While select is high, the level on the data output line is under control. It can keep the last bit driven in the previous transfer, or it can be forced to a programmed constant. The length of the gap between accesses has two settings. The short one is one serial clock period plus two system clock cycles. The extended one is a parameterised number of serial clock periods plus two system clock cycles.

Top module: `spi_idle_master`

## Requirements
- R1: While select is high after a transfer, the serial clock rests at the latched polarity level. Each transfer has exactly 2*DATA_W serial clock edges and finishes at that rest level.
- R2: Data out is MSB first. With phase 0 each bit is valid at the first (leading) edge of its clock period. With phase 1 it changes on the leading edge and is valid at the second (trailing) edge.
- R3: The input line is sampled on the same edge kind as data out is valid on (leading for phase 0, trailing for phase 1). It is packed MSB first, and the received word is on rx_data_o when done_o pulses.
- R4: done_o is a single-cycle pulse. It occurs in the first cycle in which select is high again after a transfer, and at no other time.
- R5: When idle_force_i is 1, data out equals idle_val_i (0 gives low, 1 gives high) for as long as select is high.
- R6: When idle_force_i is 0 and phase is 1, data out keeps the final level driven in the previous transfer (bit 0 of that word) while select is high. When phase is 0 the idle level is unspecified.
- R7: When gap_ext_i is 0, select stays high for at least CLK_DIV+2 system clock cycles between transfers. If start is held high, the next transfer lowers select after exactly that many cycles.
- R8: When gap_ext_i is 1, the held-start gap is exactly NAD_SCK*CLK_DIV+2 system clock cycles.
- R9: A start strobe that arrives while busy_o is high is ignored. No further transfer follows.
- R10: The first serial clock edge comes CLK_DIV system clock cycles after select falls. Select rises CLK_DIV/2 cycles after the last edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, accepted only when not busy |
| tx_data_i | input | DATA_W | Word to send, loaded at start |
| cpol_i | input | 1 | Serial clock rest level |
| cpha_i | input | 1 | 0: valid on leading edge, 1: valid on trailing edge |
| idle_force_i | input | 1 | 1: force data out while select is high |
| idle_val_i | input | 1 | Forced idle level for data out |
| gap_ext_i | input | 1 | 1: extended gap between accesses |
| miso_i | input | 1 | Serial data in |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| ss_no | output | 1 | Active-low select |
| done_o | output | 1 | Transfer complete pulse |
| busy_o | output | 1 | Transfer or gap in progress |
| rx_data_o | output | DATA_W | Last received word |

## Verification
The edge-count assertion assumes that cpol_i has been stable for at least one cycle before the start strobe. Otherwise the clock can move to a new rest level at the same edge that lowers select. The configuration inputs and idle_force_i/idle_val_i are also assumed to stay stable from start until the following gap ends. The stimulus therefore sets every configuration input a few cycles before raising start and changes it again only after done and a short pause. The input line is looped back from data out, optionally inverted, so that it changes only on the edges where the master drives data.

// File: rtl/spi_idle_pkg.sv
package spi_idle_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_TRAIL,
    ST_GAP
  } spi_state_e;
endpackage

// File: rtl/spi_tick_gen.sv
module spi_tick_gen #(
  parameter int unsigned HALF = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CW = $clog2(HALF) + 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == CW'(HALF - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              cpha_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              drive_i,
  input  logic              sample_i,
  input  logic              miso_i,
  output logic              bit_o,
  output logic [DATA_W-1:0] rx_o
);
  logic [DATA_W-1:0] tx_q;
  logic [DATA_W-1:0] rx_q;
  logic              bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q  <= '0;
      bit_q <= 1'b0;
    end else if (load_i) begin
      // phase 0 presents the MSB as soon as select falls
      if (!cpha_i) begin
        bit_q <= data_i[DATA_W-1];
        tx_q  <= {data_i[DATA_W-2:0], 1'b0};
      end else begin
        tx_q  <= data_i;
      end
    end else if (drive_i) begin
      bit_q <= tx_q[DATA_W-1];
      tx_q  <= {tx_q[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rx_q <= '0;
    else if (sample_i) rx_q <= {rx_q[DATA_W-2:0], miso_i};
  end

  assign bit_o = bit_q;
  assign rx_o  = rx_q;
endmodule

// File: rtl/spi_idle_level.sv
module spi_idle_level (
  input  logic ss_n_i,
  input  logic force_i,
  input  logic val_i,
  input  logic bit_i,
  output logic mosi_o
);
  always_comb begin
    if (ss_n_i && force_i) mosi_o = val_i;
    else                   mosi_o = bit_i;
  end
endmodule

// File: rtl/spi_idle_master.sv
module spi_idle_master
  import spi_idle_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CLK_DIV = 4,
  parameter int unsigned NAD_SCK = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic              idle_force_i,
  input  logic              idle_val_i,
  input  logic              gap_ext_i,
  input  logic              miso_i,
  output logic              sck_o,
  output logic              mosi_o,
  output logic              ss_no,
  output logic              done_o,
  output logic              busy_o,
  output logic [DATA_W-1:0] rx_data_o
);
  localparam int unsigned HALF     = CLK_DIV / 2;
  localparam int unsigned EDGES    = 2 * DATA_W;
  localparam int unsigned EW       = $clog2(EDGES);
  localparam int unsigned GAP_NORM = CLK_DIV;
  localparam int unsigned GAP_EXT  = NAD_SCK * CLK_DIV;
  localparam int unsigned GW       = $clog2(GAP_EXT + 1);
  localparam int unsigned GAP_MIN  = GAP_NORM + 2;
  localparam int unsigned HW       = $clog2(GAP_EXT + 4) + 1;

  spi_state_e        state_q;
  logic              ss_n_q, sck_q, cpol_q, cpha_q, done_q;
  logic [EW-1:0]     edge_q;
  logic [GW-1:0]     gcnt_q;
  logic [DATA_W-1:0] rx_q, rx_sh;
  logic              tick, run, lead_edge, last_edge;
  logic              load, drive, sample, bit_w;

  assign run       = (state_q == ST_LEAD) || (state_q == ST_SHIFT) || (state_q == ST_TRAIL);
  assign load      = (state_q == ST_IDLE) && start_i;
  assign lead_edge = ~edge_q[0];
  assign last_edge = (edge_q == EW'(EDGES - 1));
  assign drive     = tick && (state_q == ST_SHIFT) &&
                     (cpha_q ? lead_edge : (!lead_edge && !last_edge));
  assign sample    = tick && (state_q == ST_SHIFT) && (cpha_q ? !lead_edge : lead_edge);

  spi_tick_gen #(.HALF(HALF)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .tick_o (tick)
  );

  spi_shift_unit #(.DATA_W(DATA_W)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .cpha_i   (cpha_i),
    .data_i   (tx_data_i),
    .drive_i  (drive),
    .sample_i (sample),
    .miso_i   (miso_i),
    .bit_o    (bit_w),
    .rx_o     (rx_sh)
  );

  spi_idle_level u_idle (
    .ss_n_i  (ss_n_q),
    .force_i (idle_force_i),
    .val_i   (idle_val_i),
    .bit_i   (bit_w),
    .mosi_o  (mosi_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ss_n_q  <= 1'b1;
      sck_q   <= 1'b0;
      cpol_q  <= 1'b0;
      cpha_q  <= 1'b0;
      edge_q  <= '0;
      gcnt_q  <= '0;
      done_q  <= 1'b0;
      rx_q    <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          sck_q <= cpol_i;
          if (start_i) begin
            cpol_q  <= cpol_i;
            cpha_q  <= cpha_i;
            ss_n_q  <= 1'b0;
            edge_q  <= '0;
            state_q <= ST_LEAD;
          end
        end
        ST_LEAD: if (tick) state_q <= ST_SHIFT;
        ST_SHIFT: if (tick) begin
          sck_q  <= ~sck_q;
          edge_q <= edge_q + 1'b1;
          if (last_edge) state_q <= ST_TRAIL;
        end
        ST_TRAIL: if (tick) begin
          ss_n_q  <= 1'b1;
          done_q  <= 1'b1;
          rx_q    <= rx_sh;
          gcnt_q  <= gap_ext_i ? GW'(GAP_EXT) : GW'(GAP_NORM);
          state_q <= ST_GAP;
        end
        ST_GAP: begin
          if (gcnt_q == '0) state_q <= ST_IDLE;
          else              gcnt_q  <= gcnt_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sck_o     = sck_q;
  assign ss_no     = ss_n_q;
  assign done_o    = done_q;
  assign busy_o    = (state_q != ST_IDLE);
  assign rx_data_o = rx_q;

  // observation counters for the assertions
  logic          sck_d;
  logic [EW:0]   tog_cnt;
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_d   <= 1'b0;
      tog_cnt <= '0;
      hi_cnt  <= '1;
    end else begin
      sck_d <= sck_q;
      if (ss_n_q)              tog_cnt <= '0;
      else if (sck_q != sck_d) tog_cnt <= tog_cnt + 1'b1;
      if (!ss_n_q)             hi_cnt  <= '0;
      else if (hi_cnt != '1)   hi_cnt  <= hi_cnt + 1'b1;
    end
  end

  AST_DONE_AT_SS_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (ss_n_q && $past(!ss_n_q))); // R4
  AST_SCK_REST_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_GAP) |-> (sck_q == cpol_q)); // R1
  AST_EDGE_TOTAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ss_n_q) |-> (tog_cnt == (EW+1)'(EDGES))); // R1
  AST_GAP_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ss_n_q) |-> (hi_cnt >= HW'(GAP_MIN))); // R7
  AST_LEAD_AT_REST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ss_n_q) |-> (sck_q == cpol_q)); // R10
endmodule

// File: tb/tb_spi_idle_master.sv
module tb_spi_idle_master;
  localparam int DATA_W  = 8;
  localparam int CLK_DIV = 4;
  localparam int NAD_SCK = 4;
  localparam int HALF    = CLK_DIV / 2;

  typedef struct {
    logic [DATA_W-1:0] tx;
    logic [DATA_W-1:0] rx;
    logic              cpol;
    logic              cpha;
    logic              frc;
    logic              val;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [DATA_W-1:0] tx_data = '0;
  logic cpol = 1'b0, cpha = 1'b0, idle_force = 1'b0, idle_val = 1'b0, gap_ext = 1'b0;
  logic inv = 1'b0;
  logic miso;
  logic sck, mosi, ss_n, done, busy;
  logic [DATA_W-1:0] rx_data;

  int checks = 0;
  int errors = 0;
  bit ended = 0;
  exp_t q[$];
  exp_t cur;

  always #10 clk = ~clk;

  assign miso = mosi ^ inv;

  spi_idle_master #(.DATA_W(DATA_W), .CLK_DIV(CLK_DIV), .NAD_SCK(NAD_SCK)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .tx_data_i(tx_data),
    .cpol_i(cpol), .cpha_i(cpha), .idle_force_i(idle_force), .idle_val_i(idle_val),
    .gap_ext_i(gap_ext), .miso_i(miso), .sck_o(sck), .mosi_o(mosi), .ss_no(ss_n),
    .done_o(done), .busy_o(busy), .rx_data_o(rx_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_sim();
    if (!ended) begin
      ended = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // monitor / scoreboard
  logic prev_ss = 1'b1, prev_sck = 1'b0;
  int edges = 0, lead_t = 0, trail_t = 0, hi_cnt = 0, gap_exp = 0;
  logic [DATA_W-1:0] cap = '0;

  always @(negedge clk) if (rst_n) begin
    if (!ss_n) begin
      if (prev_ss) begin
        if (q.size() == 0) chk(0, "R9 unexpected transfer", 1, 0);
        else cur = q[0];
        edges = 0; cap = '0; lead_t = 0;
        if (gap_exp != 0) chk(hi_cnt == gap_exp, "R7/R8 gap", hi_cnt, gap_exp);
      end else if (sck != prev_sck) begin
        if (edges == 0) chk(lead_t == CLK_DIV - 1, "R10 lead", lead_t, CLK_DIV - 1);
        if (((edges % 2) == 0) == (cur.cpha == 1'b0)) cap = {cap[DATA_W-2:0], mosi};
        edges++;
        trail_t = 0;
      end else begin
        lead_t++;
        trail_t++;
      end
    end else begin
      if (!prev_ss) begin
        chk(done == 1'b1, "R4 done at select rise", done, 1);
        chk(edges == 2 * DATA_W, "R1 edge count", edges, 2 * DATA_W);
        chk(sck == cur.cpol, "R1 rest level", sck, cur.cpol);
        chk(cap == cur.tx, "R2 data out order", cap, cur.tx);
        chk(rx_data == cur.rx, "R3 received word", rx_data, cur.rx);
        chk(trail_t == HALF - 1, "R10 trail", trail_t, HALF - 1);
        if (cur.frc) chk(mosi == cur.val, "R5 forced idle level", mosi, cur.val);
        else if (cur.cpha) chk(mosi == cur.tx[0], "R6 held idle level", mosi, cur.tx[0]);
        if (q.size() > 0) void'(q.pop_front());
        hi_cnt = 1;
      end else begin
        hi_cnt++;
        if (done) chk(0, "R4 stray done", 1, 0);
      end
    end
    prev_ss = ss_n;
    prev_sck = sck;
  end

  task automatic setup(input logic p, input logic h, input logic f, input logic v,
                       input logic i, input logic g);
    @(negedge clk);
    cpol = p; cpha = h; idle_force = f; idle_val = v; inv = i; gap_ext = g;
    repeat (3) @(negedge clk);
  endtask

  function automatic exp_t mk(input logic [DATA_W-1:0] d);
    exp_t e;
    e.tx = d; e.rx = d ^ {DATA_W{inv}};
    e.cpol = cpol; e.cpha = cpha; e.frc = idle_force; e.val = idle_val;
    return e;
  endfunction

  task automatic xfer(input logic [DATA_W-1:0] d);
    q.push_back(mk(d));
    tx_data = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    repeat (2) @(negedge clk);
    if (idle_force) chk(mosi == idle_val, "R5 forced level later", mosi, idle_val);
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ss_n == 1'b1, "R4 reset select", ss_n, 1);
    chk(done == 1'b0, "R4 reset done", done, 0);
    chk(busy == 1'b0, "R9 reset busy", busy, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(sck == 1'b0, "R1 reset clock level", sck, 0);

    setup(0, 0, 1, 1, 0, 0); xfer(8'hA5);
    setup(1, 0, 1, 0, 1, 0); xfer(8'h3C);
    setup(0, 1, 0, 0, 0, 0); xfer(8'h96);
    setup(1, 1, 0, 0, 1, 0); xfer(8'h81);
    setup(0, 1, 1, 1, 1, 0); xfer(8'h5E);

    // R9: a start during a transfer must be ignored
    setup(1, 0, 1, 1, 0, 0);
    q.push_back(mk(8'hC3));
    tx_data = 8'hC3; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (10) @(negedge clk);
    tx_data = 8'h11; start = 1'b1;
    repeat (2) @(negedge clk); start = 1'b0;
    while (!done) @(negedge clk);
    begin
      int lows = 0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (!ss_n) lows++;
      end
      chk(lows == 0, "R9 no extra transfer", lows, 0);
    end

    // R7: back-to-back with the short gap
    setup(0, 1, 1, 0, 0, 0);
    q.push_back(mk(8'h4B)); q.push_back(mk(8'hD2));
    tx_data = 8'h4B; start = 1'b1;
    while (ss_n) @(negedge clk);
    tx_data = 8'hD2;
    while (!ss_n) @(negedge clk);
    gap_exp = CLK_DIV + 2;
    while (ss_n) @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    gap_exp = 0;
    while (busy) @(negedge clk);

    // R8: back-to-back with the extended gap
    setup(1, 0, 1, 1, 1, 1);
    q.push_back(mk(8'h69)); q.push_back(mk(8'h17));
    tx_data = 8'h69; start = 1'b1;
    while (ss_n) @(negedge clk);
    tx_data = 8'h17;
    while (!ss_n) @(negedge clk);
    gap_exp = NAD_SCK * CLK_DIV + 2;
    while (ss_n) @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    gap_exp = 0;
    while (busy) @(negedge clk);

    repeat (5) @(negedge clk);
    chk(q.size() == 0, "R3 all words seen", q.size(), 0);
    finish_sim();
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "WATCHDOG expired", 0, 1);
    finish_sim();
  end
endmodule